// File: doc/BRIEF.md
# Instruction Exception Entry Controller

This block sits beside the decode stage of a 32-bit pipeline with 16-bit instructions. For each valid decoded instruction it decides whether a reserved-instruction, illegal-slot or user-break exception must be taken. Its inputs are the opcode, the instruction's class flags, whether the instruction sits in a delayed-branch slot, and a break request marked as pre-execution or post-execution. When an exception is due, the block performs the entry in one clock edge. It captures the saved PC, the saved status word and the event code. It produces the new status word and issues a one-cycle redirect pulse carrying the handler address, so the pipeline can drop younger instructions.

A fault in a delay slot is reported against the delayed branch that owns the slot, and it uses a different event code from the same fault outside a slot. A break saves the breaking PC when it is taken before execution, and the following PC when it is taken after execution. A parameter chooses between two decodes of undefined opcodes: a wide one and a narrow one.

Top module: `instExcEntry`

## Requirements
- R1: A valid instruction that is not in a slot raises the reserved-instruction exception when it is undefined, or when it is privileged and SR bit 30 (MD) is 0. Event code 0x180, saved PC = that instruction's PC.
- R2: A valid instruction in a slot raises the illegal-slot exception when it is undefined, when it writes the PC, or when it is privileged with MD = 0. Event code 0x1A0, saved PC = the PC of the owning delayed branch.
- R3: With NARROW_UNDEF = 0, every opcode whose top nibble is 0xF is undefined. With NARROW_UNDEF = 1, only opcodes whose top and bottom nibbles are both 0xF are undefined.
- R4: A privileged-class instruction that is flagged as a GBR control move is treated as unprivileged and raises no exception for that reason, in or out of a slot.
- R5: A break request raises the user-break exception with event code 0x1E0. A pre-execution break saves the instruction's PC. A post-execution break saves PC + 2.
- R6: On any entry, the saved SR equals the SR presented with the faulting instruction.
- R7: On any entry, the new SR has bits 30 (MD), 29 (RB) and 28 (BL) set, and every other bit is copied from the input SR.
- R8: One cycle after the decode, redirect is high for exactly that cycle, with target VBR + 0x100.
- R9: When several causes are active together, a pre-execution break wins, then illegal-slot, then reserved-instruction, then a post-execution break.
- R10: An instruction with no cause, or with instValid low, produces no redirect and leaves the saved PC, saved SR, event code and new SR unchanged. This includes privileged instructions run with MD = 1.
- R11: After reset, redirect is low and the saved PC, saved SR, event code, new SR and target are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A decoded instruction is present |
| instOpcode | input | 16 | Opcode of the decoded instruction |
| instPriv | input | 1 | Instruction belongs to a privileged class |
| instGbrMove | input | 1 | Instruction is a control move that targets GBR |
| instPcWrite | input | 1 | Instruction rewrites the PC |
| instInSlot | input | 1 | Instruction sits in a delayed-branch slot |
| curPc | input | 32 | PC of the decoded instruction |
| branchPc | input | 32 | PC of the delayed branch that owns the slot |
| srIn | input | 32 | Current status register |
| vbrIn | input | 32 | Vector base register |
| brkReq | input | 1 | Break condition matched for this instruction |
| brkPre | input | 1 | 1 = pre-execution break, 0 = post-execution |
| spcOut | output | 32 | Saved PC |
| ssrOut | output | 32 | Saved status register |
| evtCode | output | 12 | Event code of the last entry |
| srOut | output | 32 | Status register written on the last entry |
| redirect | output | 1 | One-cycle flush and redirect pulse |
| redirectPc | output | 32 | Handler address, valid with redirect |

## Verification
The assertions assume a few things about the inputs. The class flags are meaningful only while instValid is high. The branch PC matters only when instInSlot is set. SR, VBR and the PCs are held steady around the edge that captures them. The stimulus meets these assumptions: it changes every input at the falling edge, it drives the slot flag only together with a branch PC placed just below the slot, and it keeps VBR fixed for the whole run. Priority is exercised by vectors that raise two causes at once. The narrow undefined decode is checked on a second instance.

// File: rtl/excPkg.sv
package excPkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_RESV = 2'd1,
    EXC_SLOT = 2'd2,
    EXC_BRK  = 2'd3
  } excKind_t;

  typedef enum logic [1:0] {
    PC_CUR    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_NEXT   = 2'd2
  } pcSel_t;

  typedef struct packed {
    logic     take;
    excKind_t kind;
    pcSel_t   pcSel;
  } excStrobe_t;

  localparam int EVT_W = 12;
  localparam logic [EVT_W-1:0] EVT_RESV = 12'h180;
  localparam logic [EVT_W-1:0] EVT_SLOT = 12'h1A0;
  localparam logic [EVT_W-1:0] EVT_BRK  = 12'h1E0;
endpackage

// File: rtl/excUndefDecode.sv
module excUndefDecode #(
  parameter int ILEN         = 16,
  parameter bit NARROW_UNDEF = 1'b0
) (
  input  logic [ILEN-1:0] opcode,
  output logic            isUndef
);
  localparam int NIB = 4;

  logic topAllOnes;
  assign topAllOnes = &opcode[ILEN-1 -: NIB];

  generate
    if (NARROW_UNDEF) begin : g_narrow
      assign isUndef = topAllOnes & (&opcode[NIB-1:0]);
    end else begin : g_wide
      assign isUndef = topAllOnes;
    end
  endgenerate
endmodule

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
#(
  parameter int MD_BIT = 30,
  parameter int XLEN   = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic            isUndef,
  input  logic            instPriv,
  input  logic            instGbrMove,
  input  logic            instPcWrite,
  input  logic            instInSlot,
  input  logic            brkReq,
  input  logic            brkPre,
  input  logic [XLEN-1:0] srIn,
  output excStrobe_t      strobe
);
  logic userMode, privEff, privFault, slotFault, resvFault, preBrk, postBrk;

  assign userMode  = ~srIn[MD_BIT];
  assign privEff   = instPriv & ~instGbrMove;
  assign privFault = privEff & userMode;
  assign slotFault = instValid & instInSlot & (isUndef | instPcWrite | privFault);
  assign resvFault = instValid & ~instInSlot & (isUndef | privFault);
  assign preBrk    = instValid & brkReq & brkPre;
  assign postBrk   = instValid & brkReq & ~brkPre;

  always_comb begin
    strobe = '{take: 1'b0, kind: EXC_NONE, pcSel: PC_CUR};
    if (preBrk) begin
      strobe = '{take: 1'b1, kind: EXC_BRK, pcSel: PC_CUR};
    end else if (slotFault) begin
      strobe = '{take: 1'b1, kind: EXC_SLOT, pcSel: PC_BRANCH};
    end else if (resvFault) begin
      strobe = '{take: 1'b1, kind: EXC_RESV, pcSel: PC_CUR};
    end else if (postBrk) begin
      strobe = '{take: 1'b1, kind: EXC_BRK, pcSel: PC_NEXT};
    end
  end

  // R2: an illegal-slot entry only ever comes from a slot instruction
  p_slot_only_in_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.kind == EXC_SLOT) |-> (instInSlot && instValid));

  // R9: a pre-execution break overrides every other cause
  p_pre_break_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && brkReq && brkPre) |-> (strobe.kind == EXC_BRK && strobe.pcSel == PC_CUR));

  // R10: nothing is taken without a valid instruction
  p_idle_no_take_r10: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !strobe.take);

  // R4: a GBR move alone never produces a reserved entry
  p_gbr_unpriv_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instGbrMove && !isUndef && !instPcWrite && !brkReq) |-> !strobe.take);
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INST_BYTES = 2,
  parameter int MD_BIT     = 30,
  parameter int RB_BIT     = 29,
  parameter int BL_BIT     = 28,
  parameter logic [XLEN-1:0] VEC_OFFSET = 32'h100
) (
  input  logic             clk,
  input  logic             rstN,
  input  excStrobe_t       strobe,
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  branchPc,
  input  logic [XLEN-1:0]  srIn,
  input  logic [XLEN-1:0]  vbrIn,
  output logic [XLEN-1:0]  spcOut,
  output logic [XLEN-1:0]  ssrOut,
  output logic [EVT_W-1:0] evtCode,
  output logic [XLEN-1:0]  srOut,
  output logic             redirect,
  output logic [XLEN-1:0]  redirectPc
);
  localparam logic [XLEN-1:0] SR_SET_MASK =
    (XLEN'(1) << MD_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << BL_BIT);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(INST_BYTES);

  logic [XLEN-1:0]  savePc;
  logic [EVT_W-1:0] codeSel;

  always_comb begin
    unique case (strobe.pcSel)
      PC_BRANCH: savePc = branchPc;
      PC_NEXT:   savePc = curPc + PC_STEP;
      default:   savePc = curPc;
    endcase
  end

  always_comb begin
    unique case (strobe.kind)
      EXC_SLOT: codeSel = EVT_SLOT;
      EXC_BRK:  codeSel = EVT_BRK;
      default:  codeSel = EVT_RESV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spcOut     <= '0;
      ssrOut     <= '0;
      evtCode    <= '0;
      srOut      <= '0;
      redirect   <= 1'b0;
      redirectPc <= '0;
    end else begin
      redirect <= strobe.take;
      if (strobe.take) begin
        spcOut     <= savePc;
        ssrOut     <= srIn;
        evtCode    <= codeSel;
        srOut      <= srIn | SR_SET_MASK;
        redirectPc <= vbrIn + VEC_OFFSET;
      end
    end
  end

  // R7: the control bits are set and the rest of SR is carried over
  p_sr_bits_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (srOut[MD_BIT] && srOut[RB_BIT] && srOut[BL_BIT]));
  p_sr_rest_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> ((srOut & ~SR_SET_MASK) == ($past(srIn) & ~SR_SET_MASK)));

  // R6: the saved SR is the SR seen at decode
  p_ssr_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (ssrOut == $past(srIn)));

  // R8: the handler target follows VBR
  p_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (redirectPc == $past(vbrIn) + VEC_OFFSET));

  // R10: the saved state holds when no entry happens
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> ($stable(spcOut) && $stable(evtCode) && !redirect));

  // R1: a reserved entry saves the faulting PC
  p_resv_pc_r1: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && evtCode == EVT_RESV) |-> (spcOut == $past(curPc)));
endmodule

// File: rtl/instExcEntry.sv
module instExcEntry
  import excPkg::*;
#(
  parameter int XLEN         = 32,
  parameter int ILEN         = 16,
  parameter bit NARROW_UNDEF = 1'b0,
  parameter int MD_BIT       = 30,
  parameter int RB_BIT       = 29,
  parameter int BL_BIT       = 28,
  parameter logic [XLEN-1:0] VEC_OFFSET = 32'h100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [ILEN-1:0]  instOpcode,
  input  logic             instPriv,
  input  logic             instGbrMove,
  input  logic             instPcWrite,
  input  logic             instInSlot,
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  branchPc,
  input  logic [XLEN-1:0]  srIn,
  input  logic [XLEN-1:0]  vbrIn,
  input  logic             brkReq,
  input  logic             brkPre,
  output logic [XLEN-1:0]  spcOut,
  output logic [XLEN-1:0]  ssrOut,
  output logic [EVT_W-1:0] evtCode,
  output logic [XLEN-1:0]  srOut,
  output logic             redirect,
  output logic [XLEN-1:0]  redirectPc
);
  localparam int INST_BYTES = ILEN / 8;

  logic       isUndef;
  excStrobe_t strobe;

  excUndefDecode #(.ILEN(ILEN), .NARROW_UNDEF(NARROW_UNDEF)) uDecode (
    .opcode (instOpcode),
    .isUndef(isUndef)
  );

  excCtrl #(.MD_BIT(MD_BIT), .XLEN(XLEN)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .isUndef    (isUndef),
    .instPriv   (instPriv),
    .instGbrMove(instGbrMove),
    .instPcWrite(instPcWrite),
    .instInSlot (instInSlot),
    .brkReq     (brkReq),
    .brkPre     (brkPre),
    .srIn       (srIn),
    .strobe     (strobe)
  );

  excDatapath #(
    .XLEN(XLEN), .INST_BYTES(INST_BYTES), .MD_BIT(MD_BIT),
    .RB_BIT(RB_BIT), .BL_BIT(BL_BIT), .VEC_OFFSET(VEC_OFFSET)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curPc     (curPc),
    .branchPc  (branchPc),
    .srIn      (srIn),
    .vbrIn     (vbrIn),
    .spcOut    (spcOut),
    .ssrOut    (ssrOut),
    .evtCode   (evtCode),
    .srOut     (srOut),
    .redirect  (redirect),
    .redirectPc(redirectPc)
  );
endmodule

// File: tb/sim_instExcEntry.sv
module sim_instExcEntry;
  typedef struct packed {
    logic [15:0] op;
    logic        priv;
    logic        gbr;
    logic        pcw;
    logic        slot;
    logic        brk;
    logic        pre;
    logic [31:0] sr;
    logic [1:0]  kind;  // 0 none, 1 reserved, 2 slot, 3 break
    logic [1:0]  sel;   // 0 cur, 1 branch, 2 next
  } vec_t;

  localparam logic [31:0] USR  = 32'h8000_03F3;
  localparam logic [31:0] SUP  = 32'h4000_0003;
  localparam logic [31:0] VBR  = 32'h8C00_0000;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{16'hF123, 0,0,0,0, 0,0, USR, 2'd1, 2'd0},  // R1 R3 undefined
    '{16'hF123, 0,0,0,1, 0,0, USR, 2'd2, 2'd1},  // R2 undefined in slot
    '{16'h4007, 1,0,0,0, 0,0, USR, 2'd1, 2'd0},  // R1 privileged user
    '{16'h4007, 1,0,0,0, 0,0, SUP, 2'd0, 2'd0},  // R10 privileged supervisor
    '{16'h4007, 1,0,0,1, 0,0, USR, 2'd2, 2'd1},  // R2 privileged in slot
    '{16'h4007, 1,0,0,1, 0,0, SUP, 2'd0, 2'd0},  // R10
    '{16'hA000, 0,0,1,1, 0,0, SUP, 2'd2, 2'd1},  // R2 pc write in slot
    '{16'hA000, 0,0,1,0, 0,0, USR, 2'd0, 2'd0},  // R10 branch outside slot
    '{16'h401E, 1,1,0,0, 0,0, USR, 2'd0, 2'd0},  // R4
    '{16'h401E, 1,1,0,1, 0,0, USR, 2'd0, 2'd0},  // R4 in slot
    '{16'h6003, 0,0,0,0, 1,1, USR, 2'd3, 2'd0},  // R5 pre
    '{16'h6003, 0,0,0,0, 1,0, SUP, 2'd3, 2'd2},  // R5 post
    '{16'hF000, 0,0,0,1, 1,1, USR, 2'd3, 2'd0},  // R9 pre over slot
    '{16'hF000, 0,0,0,0, 1,0, USR, 2'd1, 2'd0},  // R9 reserved over post
    '{16'hF00F, 1,0,1,1, 0,0, USR, 2'd2, 2'd1},  // R9 slot
    '{16'h6003, 0,0,0,0, 0,0, USR, 2'd0, 2'd0},  // R10 plain
    '{16'hE123, 0,0,0,0, 0,0, USR, 2'd0, 2'd0}   // R3 not 0xF
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [15:0] instOpcode = '0;
  logic instPriv = 1'b0, instGbrMove = 1'b0, instPcWrite = 1'b0, instInSlot = 1'b0;
  logic [31:0] curPc = '0, branchPc = '0, srIn = '0, vbrIn = VBR;
  logic brkReq = 1'b0, brkPre = 1'b0;
  logic [31:0] spcOut, ssrOut, srOut, redirectPc;
  logic [11:0] evtCode;
  logic redirect;
  logic [31:0] spcN, ssrN, srN, tgtN;
  logic [11:0] evtN;
  logic redN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  instExcEntry u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOpcode(instOpcode),
    .instPriv(instPriv), .instGbrMove(instGbrMove), .instPcWrite(instPcWrite),
    .instInSlot(instInSlot), .curPc(curPc), .branchPc(branchPc), .srIn(srIn),
    .vbrIn(vbrIn), .brkReq(brkReq), .brkPre(brkPre), .spcOut(spcOut),
    .ssrOut(ssrOut), .evtCode(evtCode), .srOut(srOut), .redirect(redirect),
    .redirectPc(redirectPc)
  );

  instExcEntry #(.NARROW_UNDEF(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOpcode(instOpcode),
    .instPriv(instPriv), .instGbrMove(instGbrMove), .instPcWrite(instPcWrite),
    .instInSlot(instInSlot), .curPc(curPc), .branchPc(branchPc), .srIn(srIn),
    .vbrIn(vbrIn), .brkReq(brkReq), .brkPre(brkPre), .spcOut(spcN),
    .ssrOut(ssrN), .evtCode(evtN), .srOut(srN), .redirect(redN),
    .redirectPc(tgtN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] op, input logic p, input logic g,
                       input logic w, input logic s, input logic b, input logic pr,
                       input logic [31:0] sr, input logic [31:0] pc);
    instValid = v; instOpcode = op; instPriv = p; instGbrMove = g; instPcWrite = w;
    instInSlot = s; brkReq = b; brkPre = pr; srIn = sr; curPc = pc; branchPc = pc - 32'd2;
  endtask

  initial begin
    logic [31:0] expSpc, prevSpc, pc;
    logic [11:0] expEvt, prevEvt;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 redirect", {31'b0, redirect}, 32'd0);
    chk("R11 spc", spcOut, 32'd0);
    chk("R11 ssr", ssrOut, 32'd0);
    chk("R11 evt", {20'b0, evtCode}, 32'd0);
    chk("R11 sr", srOut, 32'd0);
    chk("R11 target", redirectPc, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pc = 32'h0000_1000 + 32'(i) * 32'h10;
      prevSpc = spcOut;
      prevEvt = evtCode;
      drive(1'b1, VEC[i].op, VEC[i].priv, VEC[i].gbr, VEC[i].pcw, VEC[i].slot,
            VEC[i].brk, VEC[i].pre, VEC[i].sr, pc);
      @(negedge clk);
      if (VEC[i].kind == 2'd0) begin
        chk($sformatf("R10 no redirect v%0d", i), {31'b0, redirect}, 32'd0);
        chk($sformatf("R10 spc hold v%0d", i), spcOut, prevSpc);
        chk($sformatf("R10 evt hold v%0d", i), {20'b0, evtCode}, {20'b0, prevEvt});
      end else begin
        expEvt = (VEC[i].kind == 2'd1) ? 12'h180 : (VEC[i].kind == 2'd2) ? 12'h1A0 : 12'h1E0;
        expSpc = (VEC[i].sel == 2'd1) ? pc - 32'd2 : (VEC[i].sel == 2'd2) ? pc + 32'd2 : pc;
        chk($sformatf("R8 redirect v%0d", i), {31'b0, redirect}, 32'd1);
        chk($sformatf("R1 R2 R5 R9 evt v%0d", i), {20'b0, evtCode}, {20'b0, expEvt});
        chk($sformatf("R1 R2 R5 R9 spc v%0d", i), spcOut, expSpc);
        chk($sformatf("R6 ssr v%0d", i), ssrOut, VEC[i].sr);
        chk($sformatf("R7 sr v%0d", i), srOut, VEC[i].sr | 32'h7000_0000);
        chk($sformatf("R8 target v%0d", i), redirectPc, VBR + 32'h100);
      end
    end

    // R8 pulse lasts one cycle
    drive(1'b1, 16'hF111, 0, 0, 0, 0, 0, 0, USR, 32'h2000);
    @(negedge clk);
    chk("R8 pulse high", {31'b0, redirect}, 32'd1);
    drive(1'b0, 16'h0009, 0, 0, 0, 0, 0, 0, USR, 32'h2002);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, redirect}, 32'd0);

    // R10 invalid instruction with every cause raised
    prevSpc = spcOut;
    drive(1'b0, 16'hFFFF, 1, 0, 1, 1, 1, 1, USR, 32'h3000);
    @(negedge clk);
    chk("R10 invalid no redirect", {31'b0, redirect}, 32'd0);
    chk("R10 invalid spc hold", spcOut, prevSpc);

    // R3 narrow decode on u1
    drive(1'b1, 16'hF120, 0, 0, 0, 0, 0, 0, USR, 32'h4000);
    @(negedge clk);
    chk("R3 narrow F120 defined", {31'b0, redN}, 32'd0);
    chk("R3 wide F120 undefined", {31'b0, redirect}, 32'd1);
    drive(1'b1, 16'hF12F, 0, 0, 0, 0, 0, 0, USR, 32'h4010);
    @(negedge clk);
    chk("R3 narrow F12F undefined", {31'b0, redN}, 32'd1);
    chk("R3 narrow evt", {20'b0, evtN}, 32'h180);
    chk("R3 narrow spc", spcN, 32'h4010);
    drive(1'b0, 16'h0009, 0, 0, 0, 0, 0, 0, USR, 32'h4012);
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule